// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block is a character terminal peripheral with two separate units behind four word registers on a simple processor load/store bus. The receive unit takes bytes from a keyboard-side strobe, holds the newest one and raises a ready flag. It records an overrun when a byte replaces one that was never read. The transmit unit takes a byte written by the processor and presents it on a display-side strobe. It then reports busy for a fixed number of clock cycles, which stands in for the display finishing the character.

Both ready flags change only as side effects of bus traffic. Reading the receive data word consumes the character. Writing the transmit data word starts a new one. Each unit has an interrupt-enable bit, and it raises its own request line whenever ready and enable are both set. The receive line goes to the processor's pending-interrupt input 3 and the transmit line goes to input 2. A bus access is answered one clock later with a registered claim flag and read word.

Top module: `term_io_ctrl`

## Requirements
- R1: The block claims only word-aligned accesses at BASE_ADDR+0x0 (receive control), +0x4 (receive data), +0x8 (transmit control) and +0xC (transmit data), with the default BASE_ADDR 0xFFFF0000. For an access presented at a clock edge, `bus_hit` and `bus_rdata` are valid after that edge. `bus_rdata` is zero for writes.
- R2: In both control words, bit 0 is a read-only ready flag and bit 1 is a read/write interrupt enable. In the receive control word, bit 2 is a read-only overrun flag. All other bits read as zero. Writes to control words change only bit 1.
- R3: The data words carry the character in bits 7:0 and read zero above them. Writes to the receive data word are ignored. Reading the transmit data word returns the last byte written to it.
- R4: A `kb_valid` strobe latches `kb_data` into the receive data word and sets receive ready.
- R5: A read of the receive data word returns the held byte and clears receive ready and overrun. If a byte arrives in the same cycle, the new byte is stored, ready stays 1 and overrun ends 0.
- R6: A write to the transmit data word clears transmit ready. On the next cycle it pulses `disp_valid` for one cycle with the byte on `disp_data`.
- R7: Transmit ready returns to 1 exactly TX_DELAY cycles after the most recent transmit data write. A write made while busy restarts the full delay.
- R8: A byte that arrives while receive ready is 1, and with no read of the data word in the same cycle, overwrites the held byte and sets overrun.
- R9: `irq_rx` is high exactly while receive ready and receive enable are both 1. `irq_tx` is high exactly while transmit ready and transmit enable are both 1.
- R10: An unclaimed access (outside the four words, or misaligned) gives `bus_hit`=0 and `bus_rdata`=0 and changes no state.
- R11: After the synchronous reset, receive ready, overrun and both enables are 0, transmit ready is 1 and both data words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_hit | output | 1 | Access was claimed (registered) |
| bus_rdata | output | 32 | Load data (registered) |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_data | input | 8 | Keyboard byte |
| disp_valid | output | 1 | One-cycle display strobe |
| disp_data | output | 8 | Byte for the display |
| irq_rx | output | 1 | Receive interrupt request (pending line 3) |
| irq_tx | output | 1 | Transmit interrupt request (pending line 2) |

## Verification
A vector table of loads and stores first runs through the address map. It mixes claimed, out-of-range and misaligned addresses, and writes all-ones to read-only bits, so decode faults show up separately from flag-write faults. Directed sequences then exercise the receive flags three ways: a single byte followed by a read, two back-to-back bytes that force an overrun, and a byte arriving in the same cycle as a read. Together these separate set, clear and priority errors. The transmit delay is probed one cycle before and exactly at its end, both after a single write and after a restarting second write, which exposes off-by-one and missing-reload faults.

// File: rtl/term_io_pkg.sv
package term_io_pkg;
  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } reg_sel_e;

  localparam int BIT_READY   = 0;
  localparam int BIT_IE      = 1;
  localparam int BIT_OVERRUN = 2;
endpackage

// File: rtl/term_bus_decode.sv
module term_bus_decode
  import term_io_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output reg_sel_e          sel_idx,
  output logic              rd_rx_data,
  output logic              wr_rx_ctrl,
  output logic              wr_tx_ctrl,
  output logic              wr_tx_data
);
  localparam int WIN_LSB = 4;
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  always_comb begin
    hit     = bus_sel
            && (bus_addr[ADDR_W-1:WIN_LSB] == BASE_W[ADDR_W-1:WIN_LSB])
            && (bus_addr[1:0] == 2'b00);
    sel_idx = reg_sel_e'(bus_addr[3:2]);
    rd_rx_data = hit && !bus_we && (sel_idx == REG_RX_DATA);
    wr_rx_ctrl = hit &&  bus_we && (sel_idx == REG_RX_CTRL);
    wr_tx_ctrl = hit &&  bus_we && (sel_idx == REG_TX_CTRL);
    wr_tx_data = hit &&  bus_we && (sel_idx == REG_TX_DATA);
  end
endmodule

// File: rtl/term_rx_unit.sv
module term_rx_unit #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  input  logic              rd_data_stb,
  input  logic              wr_ctrl_stb,
  input  logic              wr_ie,
  output logic [CHAR_W-1:0] data_q,
  output logic              rdy_q,
  output logic              ie_q,
  output logic              ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ie_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_ctrl_stb) ie_q <= wr_ie;
      if (kb_valid) begin
        data_q <= kb_data;
        rdy_q  <= 1'b1;
        // a same-cycle read consumed the old byte, so no overrun
        ovr_q  <= rd_data_stb ? 1'b0 : (ovr_q | rdy_q);
      end else if (rd_data_stb) begin
        rdy_q <= 1'b0;
        ovr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/term_tx_unit.sv
module term_tx_unit #(
  parameter int CHAR_W   = 8,
  parameter int TX_DELAY = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl_stb,
  input  logic              wr_ie,
  input  logic              wr_data_stb,
  input  logic [CHAR_W-1:0] wr_char,
  output logic [CHAR_W-1:0] data_q,
  output logic              rdy_q,
  output logic              ie_q,
  output logic              disp_valid
);
  localparam int CNT_W = $clog2(TX_DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TX_DELAY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      rdy_q      <= 1'b1;
      ie_q       <= 1'b0;
      disp_valid <= 1'b0;
      cnt_q      <= '0;
    end else begin
      disp_valid <= wr_data_stb;
      if (wr_ctrl_stb) ie_q <= wr_ie;
      if (wr_data_stb) begin
        data_q <= wr_char;
        rdy_q  <= 1'b0;
        cnt_q  <= LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/term_io_ctrl.sv
module term_io_ctrl
  import term_io_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          CHAR_W    = 8,
  parameter int          TX_DELAY  = 40,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_hit,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic     dec_hit, rd_rx_data, wr_rx_ctrl, wr_tx_ctrl, wr_tx_data;
  reg_sel_e sel_idx;

  logic [CHAR_W-1:0] rx_data, tx_data;
  logic rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  term_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .hit        (dec_hit),
    .sel_idx    (sel_idx),
    .rd_rx_data (rd_rx_data),
    .wr_rx_ctrl (wr_rx_ctrl),
    .wr_tx_ctrl (wr_tx_ctrl),
    .wr_tx_data (wr_tx_data)
  );

  term_rx_unit #(.CHAR_W(CHAR_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .kb_valid    (kb_valid),
    .kb_data     (kb_data),
    .rd_data_stb (rd_rx_data),
    .wr_ctrl_stb (wr_rx_ctrl),
    .wr_ie       (bus_wdata[BIT_IE]),
    .data_q      (rx_data),
    .rdy_q       (rx_rdy),
    .ie_q        (rx_ie),
    .ovr_q       (rx_ovr)
  );

  term_tx_unit #(.CHAR_W(CHAR_W), .TX_DELAY(TX_DELAY)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .wr_ctrl_stb (wr_tx_ctrl),
    .wr_ie       (bus_wdata[BIT_IE]),
    .wr_data_stb (wr_tx_data),
    .wr_char     (bus_wdata[CHAR_W-1:0]),
    .data_q      (tx_data),
    .rdy_q       (tx_rdy),
    .ie_q        (tx_ie),
    .disp_valid  (disp_valid)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel_idx)
      REG_RX_CTRL: begin
        rd_mux[BIT_READY]   = rx_rdy;
        rd_mux[BIT_IE]      = rx_ie;
        rd_mux[BIT_OVERRUN] = rx_ovr;
      end
      REG_RX_DATA: rd_mux[CHAR_W-1:0] = rx_data;
      REG_TX_CTRL: begin
        rd_mux[BIT_READY] = tx_rdy;
        rd_mux[BIT_IE]    = tx_ie;
      end
      REG_TX_DATA: rd_mux[CHAR_W-1:0] = tx_data;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_hit   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_hit   <= dec_hit;
      bus_rdata <= (dec_hit && !bus_we) ? rd_mux : '0;
    end
  end

  assign disp_data = tx_data;
  assign irq_rx    = rx_rdy & rx_ie;
  assign irq_tx    = tx_rdy & tx_ie;
endmodule

// File: rtl/term_io_chk.sv
module term_io_chk #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_hit,
  input logic              kb_valid,
  input logic              disp_valid,
  input logic              rx_rdy,
  input logic              rx_ovr,
  input logic              tx_rdy
);
  localparam logic [ADDR_W-1:0] RXD = ADDR_W'(BASE_ADDR) + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TXD = ADDR_W'(BASE_ADDR) + ADDR_W'(12);

  logic rd_rxd, wr_txd;
  assign rd_rxd = bus_sel && !bus_we && (bus_addr == RXD);
  assign wr_txd = bus_sel &&  bus_we && (bus_addr == TXD);

  p_hit_needs_access_r10: assert property (@(posedge clk) disable iff (rst)
    bus_hit |-> $past(bus_sel));

  p_kb_sets_ready_r4: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> rx_rdy);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && !kb_valid) |=> (!rx_rdy && !rx_ovr));

  p_write_starts_tx_r6: assert property (@(posedge clk) disable iff (rst)
    wr_txd |=> (!tx_rdy && disp_valid));

  p_ready_not_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rdy) |-> !$past(wr_txd));

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (kb_valid && rx_rdy && !rd_rxd) |=> rx_ovr);
endmodule

bind term_io_ctrl term_io_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_hit    (bus_hit),
  .kb_valid   (kb_valid),
  .disp_valid (disp_valid),
  .rx_rdy     (rx_rdy),
  .rx_ovr     (rx_ovr),
  .tx_rdy     (tx_rdy)
);

// File: tb/test_term_io_ctrl.sv
module test_term_io_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TX_DLY     = 12;
  localparam int VW         = 98;
  localparam int NVEC       = 12;

  // {we, addr, wdata, expected hit, expected rdata}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 32'hFFFF_0000, 32'h0,         1'b1, 32'h0}, // R11 rx ctrl reset
    {1'b0, 32'hFFFF_0008, 32'h0,         1'b1, 32'h1}, // R11 tx ready at reset
    {1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 1'b1, 32'h0}, // R2 write all ones
    {1'b0, 32'hFFFF_0000, 32'h0,         1'b1, 32'h2}, // R2 only ie taken
    {1'b1, 32'hFFFF_0008, 32'h3,         1'b1, 32'h0}, // R2
    {1'b0, 32'hFFFF_0008, 32'h0,         1'b1, 32'h3}, // R2
    {1'b0, 32'hFFFF_0010, 32'h0,         1'b0, 32'h0}, // R10 out of range
    {1'b0, 32'hFFFF_0002, 32'h0,         1'b0, 32'h0}, // R10 misaligned
    {1'b1, 32'hFFFF_0004, 32'hAB,        1'b1, 32'h0}, // R3 rx data write
    {1'b0, 32'hFFFF_0004, 32'h0,         1'b1, 32'h0}, // R3 ignored
    {1'b1, 32'hFFFF_0008, 32'h0,         1'b1, 32'h0}, // R2 tx ie off
    {1'b0, 32'hFFFF_0008, 32'h0,         1'b1, 32'h1}  // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic bus_hit;
  logic [31:0] bus_rdata;
  logic kb_valid = 1'b0;
  logic [7:0] kb_data = '0;
  logic disp_valid;
  logic [7:0] disp_data;
  logic irq_rx, irq_tx;

  int n_chk = 0;
  int n_bad = 0;
  logic hit_s;
  logic [31:0] rd_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_io_ctrl #(.TX_DELAY(TX_DLY)) i_term_io_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_hit(bus_hit),
    .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_data(kb_data),
    .disp_valid(disp_valid), .disp_data(disp_data),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [31:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    hit_s = bus_hit; rd_s = bus_rdata;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic kb_byte(input logic [7:0] b);
    kb_valid = 1'b1; kb_data = b;
    @(posedge clk); @(negedge clk);
    kb_valid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 irq after reset", {30'b0, irq_rx, irq_tx}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_op(VEC[i][97], VEC[i][96:65], VEC[i][64:33]);
      check($sformatf("R1 vec%0d hit", i), {31'b0, hit_s}, {31'b0, VEC[i][32]});
      check($sformatf("R1 vec%0d rdata", i), rd_s, VEC[i][31:0]);
    end

    // R4 / R9: single byte with rx ie set
    kb_byte(8'h41);
    check("R9 irq_rx on ready", {31'b0, irq_rx}, 32'h1);
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R4 rx ready set", rd_s, 32'h3);
    bus_op(1'b0, 32'hFFFF_0004, '0);
    check("R4 rx byte latched", rd_s, 32'h41);
    check("R9 irq_rx cleared", {31'b0, irq_rx}, 32'h0);
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R5 ready cleared by read", rd_s, 32'h2);

    // R8 overrun
    kb_byte(8'h10);
    kb_byte(8'h22);
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R8 overrun flagged", rd_s, 32'h7);
    bus_op(1'b0, 32'hFFFF_0004, '0);
    check("R8 newest byte kept", rd_s, 32'h22);
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R5 overrun cleared", rd_s, 32'h2);

    // R5 same-cycle arrival and read
    kb_byte(8'h30);
    kb_valid = 1'b1; kb_data = 8'h31;
    bus_op(1'b0, 32'hFFFF_0004, '0);
    kb_valid = 1'b0;
    check("R5 read returns old byte", rd_s, 32'h30);
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R5 arrival wins, no overrun", rd_s, 32'h3);
    bus_op(1'b0, 32'hFFFF_0004, '0);
    check("R5 new byte stored", rd_s, 32'h31);

    // R6 / R7 transmit
    bus_op(1'b1, 32'hFFFF_0008, 32'h2);
    check("R9 irq_tx when ready and enabled", {31'b0, irq_tx}, 32'h1);
    bus_op(1'b1, 32'hFFFF_000C, 32'hDEAD_BE5A);
    check("R6 disp_valid pulse", {31'b0, disp_valid}, 32'h1);
    check("R6 disp_data", {24'b0, disp_data}, 32'h5A);
    check("R6 ready cleared", {31'b0, irq_tx}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R6 pulse one cycle", {31'b0, disp_valid}, 32'h0);
    repeat (TX_DLY - 2) @(posedge clk);
    @(negedge clk);
    check("R7 still busy at delay-1", {31'b0, irq_tx}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 ready at delay", {31'b0, irq_tx}, 32'h1);
    bus_op(1'b0, 32'hFFFF_000C, '0);
    check("R3 tx data readback", rd_s, 32'h5A);

    // R7 reload
    bus_op(1'b1, 32'hFFFF_000C, 32'h61);
    repeat (5) @(posedge clk);
    @(negedge clk);
    bus_op(1'b1, 32'hFFFF_000C, 32'h62);
    repeat (TX_DLY - 1) @(posedge clk);
    @(negedge clk);
    check("R7 reload still busy", {31'b0, irq_tx}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 reload ready", {31'b0, irq_tx}, 32'h1);

    // R10 unclaimed write changes nothing
    bus_op(1'b1, 32'hFFFE_0008, 32'h0);
    check("R10 no claim", {31'b0, hit_s}, 32'h0);
    bus_op(1'b0, 32'hFFFF_0008, '0);
    check("R10 tx ctrl unchanged", rd_s, 32'h3);

    // R11 reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    bus_op(1'b0, 32'hFFFF_0000, '0);
    check("R11 rx ctrl", rd_s, 32'h0);
    bus_op(1'b0, 32'hFFFF_0008, '0);
    check("R11 tx ctrl", rd_s, 32'h1);
    bus_op(1'b0, 32'hFFFF_000C, '0);
    check("R11 tx data", rd_s, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule